// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block drives the control pins of an asynchronous static memory bus: a 24-bit address, one active-low select per chip-select line, an active-low read strobe, an active-low write strobe, and the direction of a shared data bus. A requester presents an access on a valid/ready handshake. The block then steps through one access of a fixed number of clock cycles. Within that access each strobe and the selected chip select go low inside a window set by a setup count and a pulse count. Read data is returned together with a one-cycle completion pulse.

Two timing sets are held: one for reads and one for writes. Each set has a strobe setup, a strobe pulse, a chip-select setup, a chip-select pulse and a cycle length, all in clock cycles. The power-management logic can raise a slow-clock input. While that input is high, new accesses ignore the programmed sets and use a fixed minimal set instead, on every chip select. Software therefore does not have to reprogram the timing when the clock is slowed.

Top module: `sramStrobeGen`

## Requirements
- R1: During and after reset every chip select, the read strobe and the write strobe are high, data-bus drive is off, the completion pulse is low and the request side reports ready.
- R2: A request is taken only while the block is idle; while an access runs, request-ready stays low and a held request starts only after the running access has completed.
- R3: In normal mode, phase 0 of an access appears on the pins one cycle after the accepting edge. The access lasts exactly `cycle` phases. A strobe (or the selected chip select) is low in phase q exactly when setup <= q < setup + pulse.
- R4: With the slow-clock input high, a read lasts 2 phases. The chip select is low in phases 0 and 1, and the read strobe is low in phase 1 only.
- R5: With the slow-clock input high, a write lasts 3 phases. The chip select is low in phases 0 to 2, and the write strobe is low in phase 1 only.
- R6: The slow-clock timing replaces all programmed values on both chip-select lines. Only the chip select named by the request goes low, and every other chip select stays high.
- R7: The mode and timing are sampled at acceptance. Changing the slow-clock input or the timing inputs during an access leaves that access unchanged.
- R8: The address pins take the request address at the accepting edge and hold it, unchanged, for the whole access.
- R9: Read data is sampled on the edge at which the read strobe returns high, and is held on the read-data output when the completion pulse is given.
- R10: For a write, data-bus drive is on, and the data pins carry the request data, in exactly the phases where the chip select is low. For a read, drive stays off.
- R11: The completion pulse is one cycle wide. It appears in the cycle after the last phase, with all strobes and chip selects high.
- R12: A strobe or chip-select window that reaches past the cycle length is cut off at the end of the access. A programmed cycle length of 0 acts as 1.
- R13: The read strobe and the write strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| slowMode | input | 1 | Slow-clock indication from power management |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Block idle; request taken on this edge if valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCsSel | input | 1 | Index of the chip select to use |
| reqAddr | input | 24 | Access address |
| reqWdata | input | 16 | Write data |
| cfgRdSetup | input | 6 | Read strobe setup |
| cfgRdPulse | input | 6 | Read strobe pulse |
| cfgRdCsSetup | input | 6 | Chip-select setup for reads |
| cfgRdCsPulse | input | 6 | Chip-select pulse for reads |
| cfgRdCycle | input | 6 | Read access length |
| cfgWrSetup | input | 6 | Write strobe setup |
| cfgWrPulse | input | 6 | Write strobe pulse |
| cfgWrCsSetup | input | 6 | Chip-select setup for writes |
| cfgWrCsPulse | input | 6 | Chip-select pulse for writes |
| cfgWrCycle | input | 6 | Write access length |
| memAddr | output | 24 | Memory address pins |
| memCsN | output | 2 | Active-low chip selects |
| memRdN | output | 1 | Active-low read strobe |
| memWeN | output | 1 | Active-low write strobe |
| memDataOut | output | 16 | Data to drive on the bus |
| memDataOe | output | 1 | Data-bus drive enable |
| memDataIn | input | 16 | Data read from the bus |
| accessDone | output | 1 | One-cycle completion pulse |
| accessRdata | output | 16 | Captured read data |

## Verification
The assertions assume that the requester keeps its request fields stable from the cycle it raises `reqValid` until `reqReady` has been seen. They also assume that `reqCsSel` names an existing chip-select line. The driver task sets every request field and the timing inputs together with `reqValid`, holds all of them until acceptance, and only ever chooses select indices 0 and 1. It keeps programmed cycle lengths below 32, so one scoreboard mask covers a whole access. It changes the slow-clock input and the timing inputs only away from clock edges.

// File: rtl/sramStrobePkg.sv
package sramStrobePkg;

  localparam int CNT_W = 6;

  typedef logic [CNT_W-1:0] cntT;

  typedef struct packed {
    cntT stbSetup;
    cntT stbPulse;
    cntT csSetup;
    cntT csPulse;
    cntT cycle;
  } timT;

  localparam timT SLOW_RD = '{stbSetup: cntT'(1), stbPulse: cntT'(1),
                              csSetup: cntT'(0), csPulse: cntT'(2), cycle: cntT'(2)};
  localparam timT SLOW_WR = '{stbSetup: cntT'(1), stbPulse: cntT'(1),
                              csSetup: cntT'(0), csPulse: cntT'(3), cycle: cntT'(3)};

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} phaseT;

  typedef struct packed {
    logic load;
    logic csLow;
    logic rdLow;
    logic weLow;
    logic isWrite;
    logic done;
  } stbT;

endpackage

// File: rtl/sramStrobeCtrl.sv
module sramStrobeCtrl
  import sramStrobePkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic slowMode,
  input  logic reqValid,
  input  logic reqWrite,
  input  timT  cfgRd,
  input  timT  cfgWr,
  output logic reqReady,
  output stbT  stb
);

  phaseT state;
  cntT   cnt;
  timT   tim;
  timT   pick;
  logic  isWr;
  logic  accept;
  logic  lastPhase;

  function automatic logic inWin(cntT c, cntT s, cntT p);
    logic [CNT_W:0] endPt;
    endPt = {1'b0, s} + {1'b0, p};
    return ({1'b0, c} >= {1'b0, s}) && ({1'b0, c} < endPt);
  endfunction

  always_comb begin
    if (slowMode) pick = reqWrite ? SLOW_WR : SLOW_RD;
    else          pick = reqWrite ? cfgWr : cfgRd;
    if (pick.cycle == '0) pick.cycle = cntT'(1);
  end

  assign accept    = (state == ST_IDLE) && reqValid;
  assign lastPhase = (cnt == tim.cycle - cntT'(1));
  assign reqReady  = (state == ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tim   <= '0;
      isWr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          cnt   <= '0;
          tim   <= pick;
          isWr  <= reqWrite;
        end
        ST_RUN: begin
          if (lastPhase) state <= ST_FIN;
          else           cnt   <= cnt + cntT'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb         = '0;
    stb.load    = accept;
    stb.isWrite = isWr;
    stb.done    = (state == ST_FIN);
    if (state == ST_RUN) begin
      stb.csLow = inWin(cnt, tim.csSetup, tim.csPulse);
      stb.rdLow = !isWr && inWin(cnt, tim.stbSetup, tim.stbPulse);
      stb.weLow = isWr && inWin(cnt, tim.stbSetup, tim.stbPulse);
    end
  end

  // R3 / R12: the phase counter never reaches the latched cycle length
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> ({1'b0, cnt} < {1'b0, tim.cycle}));

  // R7: timing captured at acceptance holds for the whole access
  assert_timing_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state == ST_RUN)) |-> ($stable(tim) && $stable(isWr)));

endmodule

// File: rtl/sramStrobeDpath.sv
module sramStrobeDpath
  import sramStrobePkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 16,
  parameter int CS_NUM   = 2,
  parameter int CS_SEL_W = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  stbT                 stb,
  input  logic [CS_SEL_W-1:0] reqCsSel,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   memDataIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [CS_NUM-1:0]   memCsN,
  output logic                memRdN,
  output logic                memWeN,
  output logic [DATA_W-1:0]   memDataOut,
  output logic                memDataOe,
  output logic                accessDone,
  output logic [DATA_W-1:0]   accessRdata
);

  logic [CS_SEL_W-1:0] csSelQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr     <= '0;
      memDataOut  <= '0;
      csSelQ      <= '0;
      memRdN      <= 1'b1;
      memWeN      <= 1'b1;
      memDataOe   <= 1'b0;
      accessDone  <= 1'b0;
      accessRdata <= '0;
    end else begin
      if (stb.load) begin
        memAddr    <= reqAddr;
        memDataOut <= reqWdata;
        csSelQ     <= reqCsSel;
      end
      memRdN     <= !stb.rdLow;
      memWeN     <= !stb.weLow;
      memDataOe  <= stb.csLow && stb.isWrite;
      accessDone <= stb.done;
      if (!memRdN && !stb.rdLow) accessRdata <= memDataIn;
    end
  end

  for (genvar i = 0; i < CS_NUM; i++) begin : gCs
    logic csNBit;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) csNBit <= 1'b1;
      else       csNBit <= !(stb.csLow && (csSelQ == CS_SEL_W'(i)));
    end
    assign memCsN[i] = csNBit;
  end

  // R13: never both strobes active
  assert_no_dual_strobe_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWeN));

  // R11: completion pulse sees an idle bus and lasts one cycle
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |-> (memRdN && memWeN && (&memCsN) && !memDataOe));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    accessDone |=> !accessDone);

  // R8: address steady while any chip select is held low
  assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!(&memCsN) && $past(!(&memCsN))) |-> $stable(memAddr));

  // R10: data drive only inside a chip-select window
  assert_oe_in_cs_R10: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> !(&memCsN));

  // R6: at most one chip select low
  assert_one_cs_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~memCsN) <= 1);

endmodule

// File: rtl/sramStrobeGen.sv
module sramStrobeGen
  import sramStrobePkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int CS_NUM = 2,
  localparam int CS_SEL_W = (CS_NUM > 1) ? $clog2(CS_NUM) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                slowMode,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [CS_SEL_W-1:0] reqCsSel,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [CNT_W-1:0]    cfgRdSetup,
  input  logic [CNT_W-1:0]    cfgRdPulse,
  input  logic [CNT_W-1:0]    cfgRdCsSetup,
  input  logic [CNT_W-1:0]    cfgRdCsPulse,
  input  logic [CNT_W-1:0]    cfgRdCycle,
  input  logic [CNT_W-1:0]    cfgWrSetup,
  input  logic [CNT_W-1:0]    cfgWrPulse,
  input  logic [CNT_W-1:0]    cfgWrCsSetup,
  input  logic [CNT_W-1:0]    cfgWrCsPulse,
  input  logic [CNT_W-1:0]    cfgWrCycle,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [CS_NUM-1:0]   memCsN,
  output logic                memRdN,
  output logic                memWeN,
  output logic [DATA_W-1:0]   memDataOut,
  output logic                memDataOe,
  input  logic [DATA_W-1:0]   memDataIn,
  output logic                accessDone,
  output logic [DATA_W-1:0]   accessRdata
);

  timT cfgRd;
  timT cfgWr;
  stbT stb;

  assign cfgRd = '{stbSetup: cfgRdSetup, stbPulse: cfgRdPulse,
                   csSetup: cfgRdCsSetup, csPulse: cfgRdCsPulse, cycle: cfgRdCycle};
  assign cfgWr = '{stbSetup: cfgWrSetup, stbPulse: cfgWrPulse,
                   csSetup: cfgWrCsSetup, csPulse: cfgWrCsPulse, cycle: cfgWrCycle};

  sramStrobeCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .slowMode (slowMode),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .cfgRd    (cfgRd),
    .cfgWr    (cfgWr),
    .reqReady (reqReady),
    .stb      (stb)
  );

  sramStrobeDpath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CS_NUM   (CS_NUM),
    .CS_SEL_W (CS_SEL_W)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqCsSel    (reqCsSel),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memDataIn   (memDataIn),
    .memAddr     (memAddr),
    .memCsN      (memCsN),
    .memRdN      (memRdN),
    .memWeN      (memWeN),
    .memDataOut  (memDataOut),
    .memDataOe   (memDataOe),
    .accessDone  (accessDone),
    .accessRdata (accessRdata)
  );

endmodule

// File: tb/sramStrobeGen_test.sv
module sramStrobeGen_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, slowMode, reqValid, reqReady, reqWrite;
  logic [0:0]  reqCsSel;
  logic [23:0] reqAddr, memAddr;
  logic [15:0] reqWdata, memDataOut, memDataIn, accessRdata;
  logic [5:0]  cfgRdSetup, cfgRdPulse, cfgRdCsSetup, cfgRdCsPulse, cfgRdCycle;
  logic [5:0]  cfgWrSetup, cfgWrPulse, cfgWrCsSetup, cfgWrCsPulse, cfgWrCycle;
  logic [1:0]  memCsN;
  logic        memRdN, memWeN, memDataOe, accessDone;

  sramStrobeGen uut (.*);

  typedef struct {
    bit          isWr;
    int          cs;
    logic [23:0] addr;
    logic [15:0] wdata;
    int          cyc;
    logic [31:0] csM, rdM, weM;
    logic [15:0] rdata;
    bit          chkData;
    string       tag;
  } itemT;

  itemT q[$];
  int   checks = 0;
  int   fails  = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] win(int s, int p, int cyc);
    logic [31:0] m = '0;
    for (int i = 0; i < cyc && i < 32; i++)
      if (i >= s && i < s + p) m[i] = 1'b1;
    return m;
  endfunction

  // monitor state
  bit          tracing = 0;
  int          k;
  itemT        cur;
  logic [31:0] csS, rdS, weS, oeS;
  bit          otherLow, addrBad, doutBad, dualLow;
  logic [15:0] base;

  // driver: pushes the expected item, then presents the request until taken
  task automatic issue(bit wr, int cs, logic [23:0] a, logic [15:0] wd, bit slow,
                       int s, int p, int cS, int cP, int cyc, string tag);
    itemT it;
    int es, ep, ecs, ecp, ec, c;
    if (slow) begin
      es = 1; ep = 1; ecs = 0; ecp = wr ? 3 : 2; ec = wr ? 3 : 2;
    end else begin
      es = s; ep = p; ecs = cS; ecp = cP; ec = (cyc == 0) ? 1 : cyc;
    end
    it.isWr = wr; it.cs = cs; it.addr = a; it.wdata = wd; it.cyc = ec; it.tag = tag;
    it.csM = win(ecs, ecp, ec);
    it.rdM = wr ? 32'h0 : win(es, ep, ec);
    it.weM = wr ? win(es, ep, ec) : 32'h0;
    it.chkData = !wr && ep > 0 && es < ec;
    c = (es + ep < ec) ? es + ep : ec;
    it.rdata = (a[15:0] ^ 16'hA5A5) ^ 16'(c + 1);
    q.push_back(it);
    @(posedge clk); #1;
    slowMode = slow; reqWrite = wr; reqCsSel = 1'(cs); reqAddr = a; reqWdata = wd;
    if (wr) begin
      cfgWrSetup = 6'(s); cfgWrPulse = 6'(p); cfgWrCsSetup = 6'(cS);
      cfgWrCsPulse = 6'(cP); cfgWrCycle = 6'(cyc);
    end else begin
      cfgRdSetup = 6'(s); cfgRdPulse = 6'(p); cfgRdCsSetup = 6'(cS);
      cfgRdCsPulse = 6'(cP); cfgRdCycle = 6'(cyc);
    end
    reqValid = 1'b1;
    forever begin
      @(negedge clk);
      if (reqReady) break;
      check(tracing, "R2", "request-ready low with no access running", 0, 1);
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  // monitor: records pin traces per access and compares at completion
  always @(negedge clk) begin
    if (rstN) begin
      if (tracing) begin
        k++;
        memDataIn = base ^ 16'(k);
        if (accessDone) begin
          check(k - 2 == cur.cyc, cur.tag, "access length", k - 2, cur.cyc);
          check(csS == cur.csM, cur.tag, "chip-select phases", csS, cur.csM);
          check(rdS == cur.rdM, cur.tag, "read strobe phases", rdS, cur.rdM);
          check(weS == cur.weM, cur.tag, "write strobe phases", weS, cur.weM);
          check(oeS == (cur.isWr ? cur.csM : 32'h0), "R10", "drive phases", oeS,
                cur.isWr ? cur.csM : 32'h0);
          check(!doutBad, "R10", "write data on pins", doutBad, 0);
          check(!otherLow, "R6", "unselected chip select low", otherLow, 0);
          check(!addrBad, "R8", "address changed during access", addrBad, 0);
          check(!dualLow, "R13", "both strobes low", dualLow, 0);
          check(memRdN && memWeN && (&memCsN) && !memDataOe, "R11",
                "pins at completion", {memCsN, memRdN, memWeN, memDataOe}, 5'b11110);
          if (cur.chkData)
            check(accessRdata == cur.rdata, "R9", "read data", accessRdata, cur.rdata);
          tracing = 0;
        end else begin
          if (k >= 2 && k - 2 < 32) begin
            csS[k-2] = !memCsN[cur.cs];
            rdS[k-2] = !memRdN;
            weS[k-2] = !memWeN;
            oeS[k-2] = memDataOe;
          end
          if (!memCsN[1-cur.cs]) otherLow = 1;
          if (memAddr != cur.addr) addrBad = 1;
          if (memDataOe && memDataOut != cur.wdata) doutBad = 1;
          if (!memRdN && !memWeN) dualLow = 1;
          if (k > 40) begin
            check(0, "R11", "no completion pulse", k, cur.cyc + 2);
            tracing = 0;
          end
        end
      end
      if (!tracing && reqValid && reqReady) begin
        if (q.size() == 0) begin
          check(0, "R2", "access started with nothing expected", 1, 0);
        end else begin
          cur = q.pop_front();
          tracing = 1; k = 0;
          csS = '0; rdS = '0; weS = '0; oeS = '0;
          otherLow = 0; addrBad = 0; doutBad = 0; dualLow = 0;
          base = cur.addr[15:0] ^ 16'hA5A5;
          memDataIn = base;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R11", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; slowMode = 0; reqValid = 0; reqWrite = 0; reqCsSel = 0;
    reqAddr = '0; reqWdata = '0; memDataIn = '0;
    cfgRdSetup = 0; cfgRdPulse = 0; cfgRdCsSetup = 0; cfgRdCsPulse = 0; cfgRdCycle = 0;
    cfgWrSetup = 0; cfgWrPulse = 0; cfgWrCsSetup = 0; cfgWrCsPulse = 0; cfgWrCycle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memCsN == 2'b11 && memRdN && memWeN, "R1", "strobes in reset",
          {memCsN, memRdN, memWeN}, 4'hF);
    check(!memDataOe && !accessDone, "R1", "drive/done in reset",
          {memDataOe, accessDone}, 0);
    check(reqReady, "R1", "ready in reset", reqReady, 1);
    @(posedge clk); #1 rstN = 1;
    @(negedge clk);
    check(memCsN == 2'b11 && memRdN && memWeN && !accessDone, "R1",
          "idle after reset", {memCsN, memRdN, memWeN, accessDone}, 4'hE);

    // normal mode; second request is held behind the first (R2)
    issue(0, 0, 24'h123456, 16'h0000, 0, 2, 3, 1, 5, 7, "R3");
    issue(1, 1, 24'hABCDEF, 16'hBEEF, 0, 1, 2, 0, 4, 5, "R3");
    // slow-clock fixed timing, programmed values ignored
    issue(0, 0, 24'h001000, 16'h0000, 1, 9, 9, 9, 9, 20, "R4");
    issue(0, 1, 24'h0F2000, 16'h0000, 1, 0, 0, 5, 5, 0, "R6");
    issue(1, 0, 24'h333333, 16'h1234, 1, 7, 7, 7, 7, 30, "R5");
    issue(1, 1, 24'h444444, 16'h5678, 1, 0, 0, 0, 0, 0, "R6");
    // mode changes during an access (R7)
    issue(0, 0, 24'h555555, 16'h0000, 0, 1, 2, 0, 6, 8, "R7");
    repeat (2) @(posedge clk); #1 slowMode = 1;
    issue(1, 1, 24'h666666, 16'h9ABC, 1, 4, 4, 4, 4, 9, "R7");
    @(posedge clk); #1 slowMode = 0; cfgWrCycle = 6'd20;
    // windows past the cycle end and cycle length 0 (R12)
    issue(0, 0, 24'h777777, 16'h0000, 0, 3, 10, 1, 10, 5, "R12");
    issue(1, 1, 24'h888888, 16'hCAFE, 0, 0, 1, 0, 1, 0, "R12");
    issue(0, 1, 24'h999999, 16'h0000, 0, 0, 4, 2, 1, 4, "R12");

    while (q.size() > 0 || tracing) @(posedge clk);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(reqReady && memCsN == 2'b11 && !accessDone, "R11", "idle at end",
          {reqReady, memCsN, accessDone}, 4'b1110);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule